// File: doc/BRIEF.md
# Masked Interrupt Gather Register

This block gathers single-cycle event pulses from five interrupt sources into one active-low interrupt request. The sources are two timer underflows, a time-of-day alarm, a completed serial byte and an external flag pin. Each pulse is recorded in a sticky flag register. A separate enable mask decides which recorded events may raise the request.

Both registers share one bus address, and a read means something different from a write. A write updates the enable mask with a set/clear encoding chosen by data bit 7. A read returns the flags together with a summary bit in bit 7, then clears all of them and drops the request. The host decodes the address and presents a select strobe with separate read and write qualifiers.

Top module: `irq_gather`

## Requirements
- R1: Each source pulse sets its flag at the next clock edge, whatever the mask holds. The flag positions are bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial, bit 4 external flag.
- R2: A write with data bit 7 = 1 ORs data bits 4:0 into the mask.
- R3: A write with data bit 7 = 0 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A pulse from an enabled source sets the summary bit (bit 7 of the read value) and drives `irq_n` low at the next clock edge.
- R5: A write that enables a source whose flag is already set raises the summary bit and drives `irq_n` low at the next clock edge.
- R6: The read value is {summary, 2'b00, flags} at all times. A read strobe clears every flag and the summary, and `irq_n` returns high at the next edge.
- R7: Once asserted, `irq_n` stays low until a read, even if the mask bit is later cleared.
- R8: A pulse in the same cycle as a read strobe survives the clear. It is visible afterwards, and it sets the summary if its source is enabled.
- R9: Reset clears the flags, the summary and the mask, so `irq_n` is high and the read value is 0x00.
- R10: Read value bits 6:5 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 5 | Source event pulses, one bit per source |
| sel | input | 1 | Register select strobe |
| wr | input | 1 | Write qualifier (mask update) |
| rd | input | 1 | Read qualifier (read-and-clear) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Summary bit, two zero bits and the flags |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions check on every cycle that every pulse lands in its flag and that an enabled pulse, or a mask write that enables a pending flag, pulls the request low. They also check that the request holds low until a read and that a quiet read leaves everything clear. Only the bench scenarios show whole sequences: set and clear writes that change the mask and leave the flags alone, a read that coincides with a new event, a mask bit cleared while the request is held, and a reset in the middle of a run followed by an event that must stay masked.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int MAX_SRC = 7;

  // Set/clear mask update: data bit 7 picks OR-in or clear.
  function automatic logic [MAX_SRC-1:0] mask_upd_f(
    input logic [MAX_SRC-1:0] cur,
    input logic [7:0]         d
  );
    if (d[7]) return cur | d[MAX_SRC-1:0];
    else      return cur & ~d[MAX_SRC-1:0];
  endfunction

  // Any pending flag that is also enabled.
  function automatic logic hit_f(
    input logic [MAX_SRC-1:0] flags,
    input logic [MAX_SRC-1:0] mask
  );
    return |(flags & mask);
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_gather_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [7:0]      wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] mask_nx
);
  logic [MAX_SRC-1:0] cur_pad;
  logic [MAX_SRC-1:0] upd_pad;

  always_comb begin
    cur_pad = '0;
    cur_pad[NSRC-1:0] = mask_q;
    upd_pad = mask_upd_f(cur_pad, wdata);
    mask_nx = wr_hit ? upd_pad[NSRC-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nx;
  end
endmodule

// File: rtl/irq_flag_latch.sv
module irq_flag_latch
  import irq_gather_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            rd_hit,
  input  logic [NSRC-1:0] mask_nx,
  output logic [NSRC-1:0] flags_q,
  output logic            summary_q
);
  logic [NSRC-1:0]    flags_nx;
  logic [MAX_SRC-1:0] flags_pad;
  logic [MAX_SRC-1:0] mask_pad;
  logic               hit_nx;
  logic               summary_nx;

  always_comb begin
    // New events survive a read-clear in the same cycle.
    flags_nx  = rd_hit ? src_evt : (flags_q | src_evt);
    flags_pad = '0;
    mask_pad  = '0;
    flags_pad[NSRC-1:0] = flags_nx;
    mask_pad[NSRC-1:0]  = mask_nx;
    hit_nx     = hit_f(flags_pad, mask_pad);
    summary_nx = (rd_hit ? 1'b0 : summary_q) | hit_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      summary_q <= 1'b0;
    end else begin
      flags_q   <= flags_nx;
      summary_q <= summary_nx;
    end
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            sel,
  input  logic            wr,
  input  logic            rd,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_n
);
  localparam int SUM_BIT = DW - 1;

  logic            wr_hit;
  logic            rd_hit;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] mask_nx;
  logic [NSRC-1:0] flags_q;
  logic            summary_q;

  assign wr_hit = sel & wr;
  assign rd_hit = sel & rd;

  irq_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wdata  (wdata),
    .mask_q (mask_q),
    .mask_nx(mask_nx)
  );

  irq_flag_latch #(.NSRC(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_evt  (src_evt),
    .rd_hit   (rd_hit),
    .mask_nx  (mask_nx),
    .flags_q  (flags_q),
    .summary_q(summary_q)
  );

  always_comb begin
    rdata = '0;
    rdata[NSRC-1:0] = flags_q;
    rdata[SUM_BIT]  = summary_q;
  end

  assign irq_n = ~summary_q;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_evt,
  input logic            rd_hit,
  input logic            wr_hit,
  input logic [DW-1:0]   wdata,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] flags_q,
  input logic [DW-1:0]   rdata,
  input logic            irq_n
);
  // R1
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((rdata[NSRC-1:0] & $past(src_evt)) == $past(src_evt)));

  // R4
  enabled_evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_evt & mask_q) && !wr_hit) |=> (!irq_n && rdata[DW-1]));

  // R5
  enable_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[DW-1] && !rd_hit && |(wdata[NSRC-1:0] & flags_q)) |=> !irq_n);

  // R6
  quiet_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !(|src_evt) && !wr_hit) |=> (rdata == '0 && irq_n));

  // R7
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_hit) |=> !irq_n);

  // R10
  always_comb begin
    if (rst_n) begin
      pad_zero_chk: assert (rdata[DW-2:NSRC] == '0);
    end
  end
endmodule

bind irq_gather irq_gather_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .src_evt(src_evt),
  .rd_hit (rd_hit),
  .wr_hit (wr_hit),
  .wdata  (wdata),
  .mask_q (mask_q),
  .flags_q(flags_q),
  .rdata  (rdata),
  .irq_n  (irq_n)
);

// File: tb/irq_gather_tb_top.sv
module irq_gather_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_evt = '0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  int         n_chk = 0;
  int         n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_gather dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .sel(sel), .wr(wr),
    .rd(rd), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // {src[4:0], wr, rd, wdata[7:0], exp_rdata[7:0], exp_irq_n}
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {5'b00001, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1}, // R1 flag without mask
    {5'b00000, 1'b1, 1'b0, 8'h81, 8'h81, 1'b0}, // R2 R5 enable pending
    {5'b00000, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1}, // R6 read clears
    {5'b00010, 1'b0, 1'b0, 8'h00, 8'h02, 1'b1}, // R1 timer B masked
    {5'b00001, 1'b0, 1'b0, 8'h00, 8'h83, 1'b0}, // R4 enabled event
    {5'b00000, 1'b1, 1'b0, 8'h01, 8'h83, 1'b0}, // R3 R7 clear mask, irq held
    {5'b00100, 1'b0, 1'b1, 8'h00, 8'h04, 1'b1}, // R8 event survives read
    {5'b00001, 1'b0, 1'b0, 8'h00, 8'h05, 1'b1}, // R3 timer A now masked
    {5'b00000, 1'b1, 1'b0, 8'h9C, 8'h85, 1'b0}, // R2 R5 set bits 4:2
    {5'b00000, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1}, // R6
    {5'b10000, 1'b0, 1'b0, 8'h00, 8'h90, 1'b0}, // R1 R4 external flag bit 4
    {5'b01000, 1'b0, 1'b1, 8'h00, 8'h88, 1'b0}, // R8 enabled survivor
    {5'b00000, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1}, // R6
    {5'b00000, 1'b1, 1'b0, 8'h7F, 8'h00, 1'b1}, // R3 clear all
    {5'b11111, 1'b0, 1'b0, 8'h00, 8'h1F, 1'b1}, // R1 R10 all flags, none enabled
    {5'b00000, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1}  // R6
  };

  task automatic check(input string req, input logic [7:0] exp_r, input logic exp_i);
    n_chk++;
    if (rdata !== exp_r || irq_n !== exp_i) begin
      n_err++;
      $display("FAIL %s: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
               req, rdata, irq_n, exp_r, exp_i);
    end
  endtask

  task automatic step(input logic [4:0] s, input logic w, input logic r, input logic [7:0] d);
    src_evt = s; sel = w | r; wr = w; rd = r; wdata = d;
    @(posedge clk);
    @(negedge clk);
    src_evt = '0; sel = 1'b0; wr = 1'b0; rd = 1'b0; wdata = '0;
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: rdata=%h irq_n=%b expected completion", rdata, irq_n);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", 8'h00, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      check($sformatf("vector %0d", i), VEC[i][8:1], VEC[i][0]);
    end
    // R9: reset mid-run clears mask and flags
    step(5'b00000, 1'b1, 1'b0, 8'h9F);
    step(5'b00011, 1'b0, 1'b0, 8'h00);
    check("R4 before reset", 8'h83, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears", 8'h00, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    step(5'b00001, 1'b0, 1'b0, 8'h00);
    check("R9 mask cleared by reset", 8'h01, 1'b1);
    // R2: set write with bit 7 only changes nothing
    step(5'b00000, 1'b1, 1'b0, 8'h80);
    check("R2 empty set write", 8'h01, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule